// File: doc/BRIEF.md
# Reset Cause Status Register

This block holds a small status byte that tells firmware why the core came out of its most recent reset. Each reset source delivers a one-cycle strobe: power-on, the software reset instruction, the external clear pin, stack overflow and stack underflow. Each strobe changes only its own flag, in its own direction. The exception is power-on, which loads a whole fixed pattern.

Firmware reads the byte over a plain register bus with an address, a write enable, write data and combinational read data. After reading it, firmware rewrites the flags to arm them for the next reset. A write is accepted only in a cycle in which no reset strobe is present. The block does not generate resets and does not detect brown-out. The brown-out flag is only held and written by firmware.

Top module: `reset_cause_reg`

## Requirements
- R1: While `rstN` is low the register holds 0x0C.
- R2: A power-on strobe loads the pattern 0x0D.
- R3: A software reset strobe clears bit 2 (active-low instruction-reset flag) and leaves every other bit as it was.
- R4: A clear-pin strobe clears bit 3 (active-low pin-reset flag) and leaves every other bit as it was.
- R5: An overflow strobe sets bit 7, and an underflow strobe sets bit 6. Neither touches any other bit.
- R6: When several strobes arrive in the same cycle, the power-on pattern is applied first. The other strobes then clear or set their own flags on top of it.
- R7: A write to address 0x96 in a cycle with no strobe loads bits 0, 2, 3, 6 and 7 from the write data. Bits 1, 4 and 5 always read 0.
- R8: A write in a cycle that carries any reset strobe is dropped. The register takes only the strobe result.
- R9: Reads at 0x96 return the register, and reads at any other address return 0. A write to any other address leaves the register unchanged.
- R10: With no strobe and no accepted write, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| porEvt | input | 1 | Power-on reset strobe |
| swRstEvt | input | 1 | Software reset instruction strobe |
| pinRstEvt | input | 1 | External clear-pin reset strobe |
| stkOvfEvt | input | 1 | Stack overflow reset strobe |
| stkUnfEvt | input | 1 | Stack underflow reset strobe |
| busAddr | input | 8 | Register bus address |
| busWe | input | 1 | Register bus write enable |
| busWdata | input | 8 | Register bus write data |
| busRdata | output | 8 | Register bus read data, combinational |

## Verification
The per-flag assertions look only at the bit that a strobe owns. They therefore stay valid when strobes coincide, apart from the case where overflow or underflow arrives together with a clear of the same bit, which cannot happen because the two act on different bits. The checks that compare whole-byte stability assume that a lone strobe is not joined in the same cycle by a write that could be accepted. Because writes are dropped during strobes, that case does nothing either way. The stimulus raises every strobe for exactly one cycle and sets it up away from the clock edge. It mixes lone strobes, combined strobes and a write that collides with a strobe, so that each assertion's antecedent occurs.

// File: rtl/rcsr_pkg.sv
package rcsr_pkg;
  localparam int FLAG_W = 8;
  localparam int BIT_BOR = 0;
  localparam int BIT_INSTR = 2;
  localparam int BIT_PIN = 3;
  localparam int BIT_UNF = 6;
  localparam int BIT_OVF = 7;
  localparam logic [FLAG_W-1:0] RESET_VALUE = 8'h0C;
  localparam logic [FLAG_W-1:0] POR_PATTERN = 8'h0D;
  localparam logic [FLAG_W-1:0] IMPL_MASK =
    (FLAG_W'(1) << BIT_BOR) | (FLAG_W'(1) << BIT_INSTR) | (FLAG_W'(1) << BIT_PIN) |
    (FLAG_W'(1) << BIT_UNF) | (FLAG_W'(1) << BIT_OVF);

  typedef struct packed {
    logic loadPor;
    logic clrInstr;
    logic clrPin;
    logic setOvf;
    logic setUnf;
    logic wrEn;
    logic rdHit;
  } strobe_t;
endpackage

// File: rtl/rcsr_ctrl.sv
module rcsr_ctrl
  import rcsr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h96
) (
  input  logic              porEvt,
  input  logic              swRstEvt,
  input  logic              pinRstEvt,
  input  logic              stkOvfEvt,
  input  logic              stkUnfEvt,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobe_t           stb
);
  logic addrHit;
  logic anyEvent;

  assign addrHit  = (busAddr == REG_ADDR);
  assign anyEvent = porEvt | swRstEvt | pinRstEvt | stkOvfEvt | stkUnfEvt;

  always_comb begin
    stb          = '0;
    stb.loadPor  = porEvt;
    stb.clrInstr = swRstEvt;
    stb.clrPin   = pinRstEvt;
    stb.setOvf   = stkOvfEvt;
    stb.setUnf   = stkUnfEvt;
    // Reset strobes win over firmware writes
    stb.wrEn     = busWe & addrHit & ~anyEvent;
    stb.rdHit    = addrHit;
  end
endmodule

// File: rtl/rcsr_datapath.sv
module rcsr_datapath
  import rcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [FLAG_W-1:0] wrData,
  output logic [FLAG_W-1:0] flagsQ,
  output logic [FLAG_W-1:0] rdData
);
  logic [FLAG_W-1:0] flagsD;

  always_comb begin
    flagsD = flagsQ;
    if (stb.loadPor) flagsD = POR_PATTERN;
    if (stb.clrInstr) flagsD[BIT_INSTR] = 1'b0;
    if (stb.clrPin) flagsD[BIT_PIN] = 1'b0;
    if (stb.setOvf) flagsD[BIT_OVF] = 1'b1;
    if (stb.setUnf) flagsD[BIT_UNF] = 1'b1;
    if (stb.wrEn) flagsD = wrData & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= RESET_VALUE;
    else flagsQ <= flagsD;
  end

  assign rdData = stb.rdHit ? flagsQ : '0;
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import rcsr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h96
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porEvt,
  input  logic              swRstEvt,
  input  logic              pinRstEvt,
  input  logic              stkOvfEvt,
  input  logic              stkUnfEvt,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [FLAG_W-1:0] busWdata,
  output logic [FLAG_W-1:0] busRdata
);
  strobe_t stb;
  logic [FLAG_W-1:0] flagsQ;

  rcsr_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) ctrl (
    .porEvt(porEvt), .swRstEvt(swRstEvt), .pinRstEvt(pinRstEvt),
    .stkOvfEvt(stkOvfEvt), .stkUnfEvt(stkUnfEvt),
    .busAddr(busAddr), .busWe(busWe), .stb(stb)
  );

  rcsr_datapath dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWdata),
    .flagsQ(flagsQ), .rdData(busRdata)
  );
endmodule

// File: rtl/rcsr_checker.sv
module rcsr_checker
  import rcsr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h96
) (
  input logic              clk,
  input logic              rstN,
  input logic              porEvt,
  input logic              swRstEvt,
  input logic              pinRstEvt,
  input logic              stkOvfEvt,
  input logic              stkUnfEvt,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [FLAG_W-1:0] flagsQ
);
  logic anyEvt;
  logic wrHit;
  assign anyEvt = porEvt | swRstEvt | pinRstEvt | stkOvfEvt | stkUnfEvt;
  assign wrHit  = busWe && (busAddr == REG_ADDR);

  assert_por_pattern_R2: assert property (@(posedge clk) disable iff (!rstN)
    (porEvt && !swRstEvt && !pinRstEvt && !stkOvfEvt && !stkUnfEvt) |=> flagsQ == POR_PATTERN);

  assert_instr_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    swRstEvt |=> !flagsQ[BIT_INSTR]);

  assert_instr_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    (swRstEvt && !porEvt && !pinRstEvt && !stkOvfEvt && !stkUnfEvt) |=>
      ((flagsQ | (FLAG_W'(1) << BIT_INSTR)) == ($past(flagsQ) | (FLAG_W'(1) << BIT_INSTR))));

  assert_pin_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    pinRstEvt |=> !flagsQ[BIT_PIN]);

  assert_ovf_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    stkOvfEvt |=> flagsQ[BIT_OVF]);

  assert_unf_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    stkUnfEvt |=> flagsQ[BIT_UNF]);

  assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (flagsQ & ~IMPL_MASK) == '0);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!anyEvt && !wrHit) |=> $stable(flagsQ));
endmodule

bind reset_cause_reg rcsr_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) chk (
  .clk(clk), .rstN(rstN), .porEvt(porEvt), .swRstEvt(swRstEvt),
  .pinRstEvt(pinRstEvt), .stkOvfEvt(stkOvfEvt), .stkUnfEvt(stkUnfEvt),
  .busAddr(busAddr), .busWe(busWe), .flagsQ(flagsQ)
);

// File: tb/reset_cause_reg_test.sv
`timescale 1ns/1ps
module reset_cause_reg_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic porEvt = 0, swRstEvt = 0, pinRstEvt = 0, stkOvfEvt = 0, stkUnfEvt = 0;
  logic [7:0] busAddr = 8'h96;
  logic busWe = 0;
  logic [7:0] busWdata = 0;
  logic [7:0] busRdata;
  int checks = 0;
  int fails = 0;
  logic [7:0] expVal;

  always #2 clk = ~clk;

  reset_cause_reg uut (
    .clk(clk), .rstN(rstN), .porEvt(porEvt), .swRstEvt(swRstEvt),
    .pinRstEvt(pinRstEvt), .stkOvfEvt(stkOvfEvt), .stkUnfEvt(stkUnfEvt),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata)
  );

  task automatic check(input logic [7:0] addr, input logic [7:0] expd, input string req);
    busAddr = addr;
    #1;
    checks++;
    if (busRdata !== expd) begin
      fails++;
      $display("FAIL %s: read 0x%02h at 0x%02h, expected 0x%02h", req, busRdata, addr, expd);
    end
  endtask

  // One clock cycle with the given strobes and bus write, then idle
  task automatic cycle(input logic p, input logic s, input logic n, input logic o, input logic u,
                       input logic we, input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    porEvt = p; swRstEvt = s; pinRstEvt = n; stkOvfEvt = o; stkUnfEvt = u;
    busWe = we; busAddr = addr; busWdata = data;
    @(posedge clk);
    @(negedge clk);
    porEvt = 0; swRstEvt = 0; pinRstEvt = 0; stkOvfEvt = 0; stkUnfEvt = 0;
    busWe = 0; busAddr = 8'h96;
  endtask

  task automatic test_reset();
    check(8'h96, 8'h0C, "R1 reset value");
    check(8'h40, 8'h00, "R9 other address reads zero");
  endtask

  task automatic test_write();
    cycle(0,0,0,0,0, 1, 8'h96, 8'hFF);
    check(8'h96, 8'hCD, "R7 write all ones, unused bits zero");
    cycle(0,0,0,0,0, 1, 8'h96, 8'h00);
    check(8'h96, 8'h00, "R7 write zero");
  endtask

  task automatic test_single_events();
    cycle(1,0,0,0,0, 0, 8'h96, 8'h00);
    check(8'h96, 8'h0D, "R2 power-on pattern");
    cycle(0,1,0,0,0, 0, 8'h96, 8'h00);
    check(8'h96, 8'h09, "R3 software reset clears bit 2");
    cycle(0,0,1,0,0, 0, 8'h96, 8'h00);
    check(8'h96, 8'h01, "R4 pin reset clears bit 3");
    cycle(0,0,0,0,0, 1, 8'h96, 8'h00);
    cycle(0,0,0,1,0, 0, 8'h96, 8'h00);
    check(8'h96, 8'h80, "R5 overflow sets bit 7");
    cycle(0,0,0,0,1, 0, 8'h96, 8'h00);
    check(8'h96, 8'hC0, "R5 underflow sets bit 6");
  endtask

  task automatic test_other_addr_and_hold();
    cycle(0,0,0,0,0, 1, 8'h95, 8'h0C);
    check(8'h96, 8'hC0, "R9 write elsewhere ignored");
    repeat (3) @(negedge clk);
    check(8'h96, 8'hC0, "R10 idle hold");
  endtask

  task automatic test_combined();
    expVal = (8'h0D & ~8'h04) | 8'h80;
    cycle(1,1,0,1,0, 0, 8'h96, 8'h00);
    check(8'h96, expVal, "R6 power-on with software and overflow");
    expVal = expVal & ~8'h08;
    cycle(0,0,1,0,0, 1, 8'h96, 8'h00);
    check(8'h96, expVal, "R8 write dropped during pin strobe");
    expVal = (8'h0D & ~8'h08) | 8'h40;
    cycle(1,0,1,0,1, 1, 8'h96, 8'hFF);
    check(8'h96, expVal, "R6 power-on with pin and underflow, R8 write dropped");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    test_reset();
    test_write();
    test_single_events();
    test_other_addr_and_hold();
    test_combined();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung, expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule